// File: doc/BRIEF.md
# Triggered Sample Record Logger

The logger decides when a user circuit's data is captured into memory and packs each capture into a fixed-size record. A global run bit must be set before anything can happen. Within that, a log-enable level requests starting or stopping, and a trigger-mode setting chooses between rising-edge-enable and falling-edge-enable. A start request is honoured only in rising-edge-enable mode. A stop request is honoured only in falling-edge-enable mode. A request made in the wrong mode is refused: the block reports a minor-error code and keeps its current state.

While logging, each one-clock sampling pulse creates one record. The record holds a free-running time stamp in its upper bits and the user data word in its lower bits. The record goes out on a request/acknowledge write port with an address. The first record after each start uses a base address, and each later record advances the address by a fixed stride. The write port holds one record at a time. A pulse that arrives while a write still waits for acknowledge is dropped and raises a sticky overflow flag.

Top module: `sample_logger_top`

## Requirements
- R1: Logging can start only while `run_en` is 1. If `run_en` is 0 while logging, logging stops on the next clock edge. A start or stop conflict seen while `run_en` is 0 raises no error.
- R2: With `run_en`=1, `log_en`=1 and `trig_rise`=1 (rising-edge-enable) while idle, `logging` becomes 1 after the next clock edge.
- R3: With `log_en`=1 and `trig_rise`=0 (falling-edge-enable) while idle, logging does not start, and `err_code` reads 16'h1430 with `err_valid` set.
- R4: With `log_en`=0 and `trig_rise`=1 while logging, logging continues and records are still written. `err_code` reads 16'h1431 with `err_valid` set.
- R5: Logging stops only when `log_en`=0 and `trig_rise`=0, or when `run_en` drops. `logging` reads 0 after the next edge.
- R6: `err_valid` is a one-cycle strobe. It appears one cycle after a conflict condition first becomes true and is not repeated while that condition persists.
- R7: `wr_data` holds the 80-bit time stamp in bits [511:432] and the 432-bit sample data in bits [431:0]. The time stamp is 0 during reset and counts every clock edge after reset. It is captured at the edge where `sample_pulse` is seen.
- R8: While logging, each `sample_pulse` cycle produces exactly one record on the write port. While idle, pulses produce no record.
- R9: The first record after each start is written to address BASE (default 32'h1000). Each later accepted record is written to the previous address plus STRIDE (default 64). Dropped records do not advance the address.
- R10: `wr_req` stays high with stable `wr_addr` and `wr_data` until `wr_ack` is seen. A pulse in the same cycle as `wr_ack` is accepted as the next record.
- R11: A pulse while `wr_req`=1 and `wr_ack`=0 is dropped. The outstanding record is kept, and `overflow` is set. `overflow` stays set until the next start.
- R12: After reset, `logging`, `wr_req`, `err_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Global internal-operation run bit |
| log_en | input | 1 | Log-enable level (1 request start, 0 request stop) |
| trig_rise | input | 1 | Trigger mode: 1 rising-edge-enable, 0 falling-edge-enable |
| sample_pulse | input | 1 | One-clock sampling pulse |
| sample_data | input | 432 | User data word |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 512 | Record: time stamp over data |
| wr_ack | input | 1 | Write acknowledge |
| logging | output | 1 | Logging active |
| err_valid | output | 1 | One-cycle error strobe |
| err_code | output | 16 | Minor-error code |
| overflow | output | 1 | Sticky record-dropped flag |

## Verification
The hardest situations to reach are the two write-port corners: a pulse that lands while a record is still unacknowledged, and a pulse that lands in the same cycle as the acknowledge. The bench holds `wr_ack` low across one pulse to force a drop. It then checks that the held record and the address sequence are both unchanged. It also raises `wr_ack` and a new pulse on the same cycle. The stop-conflict case is reached by clearing `log_en` in rising-edge-enable mode, then pulsing to confirm that records continue at the next stride.

// File: rtl/slog_pkg.sv
package slog_pkg;

    localparam int unsigned STAMP_W_DEF = 80;
    localparam int unsigned DATA_W_DEF  = 432;
    localparam int unsigned CODE_W      = 16;

    localparam logic [CODE_W-1:0] CODE_START_CONFLICT = 16'h1430;
    localparam logic [CODE_W-1:0] CODE_STOP_CONFLICT  = 16'h1431;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOG  = 1'b1
    } log_state_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } err_evt_t;

    function automatic err_evt_t pick_error(input logic new_start_c,
                                            input logic new_stop_c);
        err_evt_t e;
        e.valid = new_start_c | new_stop_c;
        e.code  = new_start_c ? CODE_START_CONFLICT :
                  new_stop_c  ? CODE_STOP_CONFLICT  : '0;
        return e;
    endfunction

endpackage

// File: rtl/slog_timebase.sv
module slog_timebase #(
    parameter int unsigned STAMP_W = slog_pkg::STAMP_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    output logic [STAMP_W-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (rst) stamp <= '0;
        else     stamp <= stamp + 1'b1;
    end

    p_stamp_counts_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stamp == $past(stamp) + 1'b1);
endmodule

// File: rtl/slog_ctrl.sv
module slog_ctrl
    import slog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              log_en,
    input  logic              trig_rise,
    output logic              active,
    output logic              restart,
    output logic              err_valid,
    output logic [CODE_W-1:0] err_code
);
    log_state_t st;
    logic start_ok, stop_ok, start_c, stop_c, start_c_q, stop_c_q;
    err_evt_t   evt;

    always_comb begin
        start_ok = (st == ST_IDLE) & run_en & log_en & trig_rise;
        start_c  = (st == ST_IDLE) & run_en & log_en & ~trig_rise;
        stop_c   = (st == ST_LOG)  & run_en & ~log_en & trig_rise;
        stop_ok  = (st == ST_LOG)  & (~run_en | (~log_en & ~trig_rise));
    end

    assign active  = (st == ST_LOG);
    assign restart = start_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            start_c_q <= 1'b0;
            stop_c_q  <= 1'b0;
            evt       <= '0;
        end else begin
            if (start_ok)     st <= ST_LOG;
            else if (stop_ok) st <= ST_IDLE;
            start_c_q <= start_c;
            stop_c_q  <= stop_c;
            evt       <= pick_error(start_c & ~start_c_q, stop_c & ~stop_c_q);
        end
    end

    assign err_valid = evt.valid;
    assign err_code  = evt.code;

    p_start_gated_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(run_en));
    p_stop_conflict_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (active && run_en && !log_en && trig_rise) |=> active);
    p_err_single_r6: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid);
    p_err_code_known_r3: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code == CODE_START_CONFLICT || err_code == CODE_STOP_CONFLICT));
endmodule

// File: rtl/slog_writer.sv
module slog_writer #(
    parameter int unsigned STAMP_W = slog_pkg::STAMP_W_DEF,
    parameter int unsigned DATA_W  = slog_pkg::DATA_W_DEF,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned STRIDE  = 64,
    parameter logic [ADDR_W-1:0] BASE = 32'h0000_1000,
    localparam int unsigned REC_W  = STAMP_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               restart,
    input  logic               sample,
    input  logic [STAMP_W-1:0] stamp,
    input  logic [DATA_W-1:0]  data,
    input  logic               wr_ack,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [REC_W-1:0]   wr_data,
    output logic               overflow
);
    logic [ADDR_W-1:0] next_addr;
    logic pending, take, drop;

    always_comb begin
        pending = wr_req & ~wr_ack;
        take    = active & sample & ~pending;
        drop    = active & sample & pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_req    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            next_addr <= BASE;
            overflow  <= 1'b0;
        end else begin
            if (restart) begin
                next_addr <= BASE;
                overflow  <= 1'b0;
            end else if (take) begin
                next_addr <= next_addr + ADDR_W'(STRIDE);
            end
            if (take) begin
                wr_req  <= 1'b1;
                wr_addr <= next_addr;
                wr_data <= {stamp, data};
            end else if (wr_req && wr_ack) begin
                wr_req <= 1'b0;
            end
            if (drop) overflow <= 1'b1;
        end
    end

    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    p_overflow_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (overflow && !restart) |=> overflow);
    p_no_write_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!active && !wr_req) |=> !wr_req);
endmodule

// File: rtl/sample_logger_top.sv
module sample_logger_top #(
    parameter int unsigned STAMP_W = slog_pkg::STAMP_W_DEF,
    parameter int unsigned DATA_W  = slog_pkg::DATA_W_DEF,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned STRIDE  = 64,
    parameter logic [ADDR_W-1:0] BASE = 32'h0000_1000,
    localparam int unsigned REC_W  = STAMP_W + DATA_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        run_en,
    input  logic                        log_en,
    input  logic                        trig_rise,
    input  logic                        sample_pulse,
    input  logic [DATA_W-1:0]           sample_data,
    output logic                        wr_req,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [REC_W-1:0]            wr_data,
    input  logic                        wr_ack,
    output logic                        logging,
    output logic                        err_valid,
    output logic [slog_pkg::CODE_W-1:0] err_code,
    output logic                        overflow
);
    logic [STAMP_W-1:0] stamp;
    logic               restart;

    slog_timebase #(.STAMP_W(STAMP_W)) u_time (
        .clk(clk), .rst(rst), .stamp(stamp)
    );

    slog_ctrl u_ctrl (
        .clk(clk), .rst(rst), .run_en(run_en), .log_en(log_en),
        .trig_rise(trig_rise), .active(logging), .restart(restart),
        .err_valid(err_valid), .err_code(err_code)
    );

    slog_writer #(
        .STAMP_W(STAMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .STRIDE(STRIDE), .BASE(BASE)
    ) u_wr (
        .clk(clk), .rst(rst), .active(logging), .restart(restart),
        .sample(sample_pulse), .stamp(stamp), .data(sample_data),
        .wr_ack(wr_ack), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .overflow(overflow)
    );
endmodule

// File: tb/test_sample_logger_top.sv
module test_sample_logger_top;
    localparam int unsigned DW = 432;
    localparam int unsigned TW = 80;
    localparam int unsigned RW = 512;
    localparam logic [31:0] BASE = 32'h0000_1000;
    localparam logic [31:0] STRIDE = 32'd64;

    logic clk = 1'b0;
    logic rst, run_en, log_en, trig_rise, sample_pulse, wr_ack;
    logic [DW-1:0] sample_data;
    logic wr_req, logging, err_valid, overflow;
    logic [31:0] wr_addr;
    logic [RW-1:0] wr_data;
    logic [15:0] err_code;
    logic [TW-1:0] tb_time;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) tb_time <= '0;
        else     tb_time <= tb_time + 1'b1;
    end

    sample_logger_top i_sample_logger_top (
        .clk(clk), .rst(rst), .run_en(run_en), .log_en(log_en),
        .trig_rise(trig_rise), .sample_pulse(sample_pulse),
        .sample_data(sample_data), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .logging(logging),
        .err_valid(err_valid), .err_code(err_code), .overflow(overflow)
    );

    // [20] run [19] log_en [18] trig_rise [17] exp logging [16] exp err_valid [15:0] exp code
    localparam logic [20:0] VECS [10] = '{
        {3'b011, 2'b00, 16'h0000},  // R1: no start without run
        {3'b110, 2'b01, 16'h1430},  // R3: start conflict
        {3'b110, 2'b00, 16'h0000},  // R6: not repeated
        {3'b100, 2'b00, 16'h0000},
        {3'b111, 2'b10, 16'h0000},  // R2: start
        {3'b101, 2'b11, 16'h1431},  // R4: stop conflict
        {3'b101, 2'b10, 16'h0000},  // R6: not repeated
        {3'b100, 2'b00, 16'h0000},  // R5: stop
        {3'b111, 2'b10, 16'h0000},  // R2: restart
        {3'b011, 2'b00, 16'h0000}   // R1: run drop stops
    };

    function automatic logic [DW-1:0] pat(input logic [15:0] s);
        return {27{s}};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] s, output logic [TW-1:0] t);
        sample_data  = pat(s);
        sample_pulse = 1'b1;
        t = tb_time;
        step();
        sample_pulse = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] t1, t2, t3, t4, t5;
        rst = 1'b1; run_en = 0; log_en = 0; trig_rise = 0;
        sample_pulse = 0; wr_ack = 0; sample_data = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R12 logging", RW'(logging), RW'(0));
        chk("R12 wr_req", RW'(wr_req), RW'(0));
        chk("R12 err_valid", RW'(err_valid), RW'(0));
        chk("R12 overflow", RW'(overflow), RW'(0));

        for (int i = 0; i < 10; i++) begin
            {run_en, log_en, trig_rise} = VECS[i][20:18];
            step();
            chk($sformatf("R1 R2 R3 R5 vec %0d logging", i), RW'(logging), RW'(VECS[i][17]));
            chk($sformatf("R3 R4 R6 vec %0d err_valid", i), RW'(err_valid), RW'(VECS[i][16]));
            if (VECS[i][16])
                chk($sformatf("R3 R4 vec %0d code", i), RW'(err_code), RW'(VECS[i][15:0]));
        end

        pulse(16'h0BAD, t1);
        chk("R8 idle pulse no write", RW'(wr_req), RW'(0));

        run_en = 1; log_en = 1; trig_rise = 1;
        step();
        chk("R2 started", RW'(logging), RW'(1));
        pulse(16'hA5C3, t1);
        chk("R8 record req", RW'(wr_req), RW'(1));
        chk("R9 first addr", RW'(wr_addr), RW'(BASE));
        chk("R7 record layout", wr_data, {t1, pat(16'hA5C3)});
        step();
        chk("R10 hold req", RW'(wr_req), RW'(1));
        chk("R10 hold data", wr_data, {t1, pat(16'hA5C3)});

        wr_ack = 1;
        pulse(16'h1234, t2);
        wr_ack = 0;
        chk("R10 accept on ack", RW'(wr_req), RW'(1));
        chk("R9 second addr", RW'(wr_addr), RW'(BASE + STRIDE));
        chk("R7 second data", wr_data, {t2, pat(16'h1234)});

        pulse(16'h7777, t3);
        chk("R11 overflow set", RW'(overflow), RW'(1));
        chk("R11 record kept", wr_data, {t2, pat(16'h1234)});
        wr_ack = 1;
        step();
        wr_ack = 0;
        chk("R10 released", RW'(wr_req), RW'(0));

        log_en = 0;
        step();
        chk("R4 still logging", RW'(logging), RW'(1));
        chk("R4 error strobe", RW'(err_valid), RW'(1));
        chk("R4 code", RW'(err_code), RW'(16'h1431));
        pulse(16'hC0DE, t4);
        chk("R4 record written", RW'(wr_req), RW'(1));
        chk("R9 dropped no advance", RW'(wr_addr), RW'(BASE + 2 * STRIDE));
        chk("R7 stamp data", wr_data, {t4, pat(16'hC0DE)});
        chk("R11 overflow sticky", RW'(overflow), RW'(1));
        wr_ack = 1;
        step();
        wr_ack = 0;

        trig_rise = 0;
        step();
        chk("R5 stopped", RW'(logging), RW'(0));
        pulse(16'hBEEF, t5);
        chk("R8 no record idle", RW'(wr_req), RW'(0));

        log_en = 1; trig_rise = 1;
        step();
        chk("R11 overflow cleared", RW'(overflow), RW'(0));
        pulse(16'h5A5A, t5);
        chk("R9 addr reset", RW'(wr_addr), RW'(BASE));
        chk("R7 restart data", wr_data, {t5, pat(16'h5A5A)});

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule